// File: doc/BRIEF.md
# EEPROM Save Instruction Sequencer

This block copies chosen ranges of a register map into a byte-wide EEPROM and leaves a self-describing image behind. A short list of instruction bytes is captured on a start pulse. Each instruction either asks for a block copy or marks a point where an I/O update belongs. A block copy carries a length code and a two-byte start address. The sequencer writes every instruction byte and every address byte into the EEPROM, then the copied bytes, and closes each copied block with a checksum byte. A later loader can replay the image without any outside description of its layout.

Register-map reads have a fixed latency of one cycle. EEPROM writes go through a valid/ready handshake, so a slow storage back end can stall the sequencer at any byte. The EEPROM pointer starts at zero on every run. An error flag reports opcodes that were not understood, and an overflow flag reports a pointer that wrapped.

Top module: `eesave_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, ovf_o, ee_valid_o and rm_rd_o are all low.
- R2: start_i is acted on only while busy_o is low. It captures list_i, where byte k is list_i[8k+7:8k], clears err_o and ovf_o, and raises busy_o in the next cycle. A start_i pulse while busy_o is high, or a change of list_i during a run, leaves the written image unchanged.
- R3: A list byte N from 0x00 to 0x7F is a copy instruction. N is written, then the next two list bytes are written as the start address, high byte first.
- R4: After the address, N+1 bytes are read from register-map addresses A, A+1, ..., A+N, where A is the 16-bit start address and the addition wraps modulo 2^RM_AW. They are written in that order. Each rm_rd_o cycle returns its byte on rm_data_i in the following cycle.
- R5: After the last copied byte, one checksum byte is written. It equals the two's complement of the modulo-256 sum of that block's copied bytes.
- R6: List byte 0x80 is written as an I/O-update marker with no copy, and the walk continues at the next list byte.
- R7: List byte 0xFF is written and ends the run. done_o is high for exactly one cycle, the cycle after that write is accepted, and busy_o is already low in that cycle.
- R8: Any list byte from 0x81 to 0xFE is not written and is skipped, and err_o is set. err_o stays high until the next accepted start.
- R9: A write counts only in a cycle where ee_valid_o and ee_ready_i are both high. While ee_ready_i is low, ee_valid_o stays high and ee_addr_o and ee_data_o stay stable.
- R10: ee_addr_o starts at 0 on each run and advances by one per accepted write, wrapping at 2^EE_AW. An accepted write at address 2^EE_AW-1 sets ovf_o, which stays high until the next accepted start.
- R11: List positions at or past LIST_LEN read as 0xFF. A list without an end byte, or a copy instruction whose address bytes run past the list, therefore still ends with a written 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; captures the list |
| list_i | input | LIST_LEN*8 | Instruction list, byte k in bits [8k+7:8k] |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse after the end byte is written |
| err_o | output | 1 | Sticky: an unknown opcode was skipped |
| ovf_o | output | 1 | Sticky: the EEPROM pointer wrapped |
| rm_rd_o | output | 1 | Register-map read strobe |
| rm_addr_o | output | RM_AW | Register-map read address |
| rm_data_i | input | 8 | Register-map read data, one cycle after rm_rd_o |
| ee_valid_o | output | 1 | EEPROM write request |
| ee_ready_i | input | 1 | EEPROM accepts the write |
| ee_addr_o | output | EE_AW | EEPROM byte address |
| ee_data_o | output | 8 | EEPROM byte data |

## Verification
The bench targets the places where the image is easy to corrupt. These are back-pressure that lands on an address or checksum byte, a copy starting at 0xFFFF that must wrap to 0x0000, and a copy long enough to wrap the EEPROM pointer. A design that let data move while stalled would write shifted or doubled bytes. A design that read the register map without the latency cycle would write every copied byte one address early. The bench also mixes bad opcodes with markers, sends a restart pulse and a changed list in the middle of a run, and walks off the end of a list that has no end byte. A wrong design would leak bad opcodes into the image, restart from zero, or hang without done_o.

// File: rtl/eesave_pkg.sv
package eesave_pkg;
   localparam logic [7:0] OP_COPY_MAX = 8'h7F;
   localparam logic [7:0] OP_MARK     = 8'h80;
   localparam logic [7:0] OP_END      = 8'hFF;

   typedef enum logic [3:0] {
      S_IDLE, S_FETCH, S_WR_OP, S_WR_AHI, S_WR_ALO,
      S_RD, S_LAT, S_WR_DAT, S_WR_CS
   } seq_st_e;

   typedef enum logic [1:0] {K_COPY, K_MARK, K_END} op_kind_e;
endpackage

// File: rtl/eesave_list.sv
module eesave_list #(
   parameter int LIST_LEN = 16,
   parameter int IW       = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [LIST_LEN*8-1:0] list_i,
   input  logic [IW-1:0]         idx,
   output logic [7:0]            byte_o
);
   localparam int SEL_W = (LIST_LEN > 1) ? $clog2(LIST_LEN) : 1;

   logic [7:0] mem [LIST_LEN];

   for (genvar g = 0; g < LIST_LEN; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    mem[g] <= 8'hFF;
         else if (load) mem[g] <= list_i[g*8 +: 8];
      end
   end

   // R11: positions past the list read as the end opcode
   always_comb begin
      if (idx < IW'(LIST_LEN)) byte_o = mem[idx[SEL_W-1:0]];
      else                     byte_o = 8'hFF;
   end

   // R2
   list_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(mem[0]));
endmodule

// File: rtl/eesave_ptr.sv
module eesave_ptr #(
   parameter int EE_AW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [EE_AW-1:0] ptr_o,
   output logic             ovf_o
);
   localparam logic [EE_AW-1:0] LAST = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_o <= '0;
         ovf_o <= 1'b0;
      end else if (clr) begin
         ptr_o <= '0;
         ovf_o <= 1'b0;
      end else if (adv) begin
         ptr_o <= ptr_o + 1'b1;
         if (ptr_o == LAST) ovf_o <= 1'b1;
      end
   end

   // R10
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !adv) |=> $stable(ptr_o));
endmodule

// File: rtl/eesave_csum.sv
module eesave_csum (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       add,
   input  logic [7:0] din,
   output logic [7:0] csum_o
);
   logic [7:0] sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sum_q <= '0;
      else if (clr) sum_q <= '0;
      else if (add) sum_q <= sum_q + din;
   end

   assign csum_o = 8'h00 - sum_q;

   // R5
   csum_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (csum_o == 8'h00));
endmodule

// File: rtl/eesave_seq.sv
module eesave_seq
   import eesave_pkg::*;
#(
   parameter int LIST_LEN = 16,
   parameter int RM_AW    = 16,
   parameter int EE_AW    = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [LIST_LEN*8-1:0] list_i,
   output logic                  busy_o,
   output logic                  done_o,
   output logic                  err_o,
   output logic                  ovf_o,
   output logic                  rm_rd_o,
   output logic [RM_AW-1:0]      rm_addr_o,
   input  logic [7:0]            rm_data_i,
   output logic                  ee_valid_o,
   input  logic                  ee_ready_i,
   output logic [EE_AW-1:0]      ee_addr_o,
   output logic [7:0]            ee_data_o
);
   localparam int IW = $clog2(LIST_LEN + 3) + 1;
   localparam logic [EE_AW-1:0] EE_LAST = '1;

   if (LIST_LEN < 3) begin : g_bad_list
      $error("eesave_seq: LIST_LEN must hold one copy instruction");
   end
   if (RM_AW < 8 || RM_AW > 16) begin : g_bad_rm
      $error("eesave_seq: RM_AW must be 8..16");
   end
   if (EE_AW < 2) begin : g_bad_ee
      $error("eesave_seq: EE_AW too small");
   end

   seq_st_e    st_q;
   op_kind_e   kind_q;
   logic [7:0] op_q;
   logic [IW-1:0] idx_q;
   logic [15:0] base_q;
   logic [6:0] cnt_q;
   logic [7:0] hold_q;
   logic       err_q, done_q;

   logic [7:0] lbyte;
   logic [7:0] csum;
   logic       acc, go;
   logic [15:0] rd_addr16;

   assign go  = (st_q == S_IDLE) && start_i;
   assign acc = ee_valid_o && ee_ready_i;

   eesave_list #(.LIST_LEN(LIST_LEN), .IW(IW)) u_list (
      .clk(clk), .rst_n(rst_n), .load(go), .list_i(list_i),
      .idx(idx_q), .byte_o(lbyte));

   eesave_ptr #(.EE_AW(EE_AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .clr(go), .adv(acc),
      .ptr_o(ee_addr_o), .ovf_o(ovf_o));

   eesave_csum u_csum (
      .clk(clk), .rst_n(rst_n),
      .clr(st_q == S_WR_ALO && acc),
      .add(st_q == S_LAT),
      .din(rm_data_i), .csum_o(csum));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         kind_q <= K_END;
         op_q   <= '0;
         idx_q  <= '0;
         base_q <= '0;
         cnt_q  <= '0;
         hold_q <= '0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            S_IDLE: if (start_i) begin
               st_q  <= S_FETCH;
               idx_q <= '0;
               err_q <= 1'b0;
            end
            S_FETCH: begin
               op_q <= lbyte;
               if (lbyte <= OP_COPY_MAX) begin
                  kind_q <= K_COPY;
                  st_q   <= S_WR_OP;
               end else if (lbyte == OP_MARK) begin
                  kind_q <= K_MARK;
                  st_q   <= S_WR_OP;
               end else if (lbyte == OP_END) begin
                  kind_q <= K_END;
                  st_q   <= S_WR_OP;
               end else begin
                  err_q <= 1'b1;          // R8: skip unknown opcode
                  idx_q <= idx_q + 1'b1;
               end
            end
            S_WR_OP: if (acc) begin
               idx_q <= idx_q + 1'b1;
               case (kind_q)
                  K_COPY:  st_q <= S_WR_AHI;
                  K_MARK:  st_q <= S_FETCH;
                  default: begin
                     st_q   <= S_IDLE;
                     done_q <= 1'b1;
                  end
               endcase
            end
            S_WR_AHI: if (acc) begin
               base_q[15:8] <= lbyte;
               idx_q        <= idx_q + 1'b1;
               st_q         <= S_WR_ALO;
            end
            S_WR_ALO: if (acc) begin
               base_q[7:0] <= lbyte;
               idx_q       <= idx_q + 1'b1;
               cnt_q       <= '0;
               st_q        <= S_RD;
            end
            S_RD:  st_q <= S_LAT;
            S_LAT: begin
               hold_q <= rm_data_i;
               st_q   <= S_WR_DAT;
            end
            S_WR_DAT: if (acc) begin
               if (cnt_q == op_q[6:0]) st_q <= S_WR_CS;
               else begin
                  cnt_q <= cnt_q + 1'b1;
                  st_q  <= S_RD;
               end
            end
            S_WR_CS: if (acc) st_q <= S_FETCH;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign rd_addr16 = base_q + {9'd0, cnt_q};
   assign rm_addr_o = rd_addr16[RM_AW-1:0];
   assign rm_rd_o   = (st_q == S_RD);
   assign busy_o    = (st_q != S_IDLE);
   assign done_o    = done_q;
   assign err_o     = err_q;

   always_comb begin
      ee_valid_o = 1'b1;
      ee_data_o  = op_q;
      case (st_q)
         S_WR_OP:  ee_data_o = op_q;
         S_WR_AHI: ee_data_o = lbyte;
         S_WR_ALO: ee_data_o = lbyte;
         S_WR_DAT: ee_data_o = hold_q;
         S_WR_CS:  ee_data_o = csum;
         default:  ee_valid_o = 1'b0;
      endcase
   end

   // R9
   ee_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_valid_o && !ee_ready_i) |=>
         (ee_valid_o && $stable(ee_data_o) && $stable(ee_addr_o)));

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R10
   wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ee_addr_o == EE_LAST) |=> ovf_o);

   // R4
   rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rm_rd_o |=> (!rm_rd_o && !ee_valid_o));

   // R2
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=>
         (busy_o && !err_o && !ovf_o && ee_addr_o == '0));
endmodule

// File: tb/tb_eesave_seq.sv
module tb_eesave_seq;
   localparam int LIST_LEN = 16;
   localparam int RM_AW    = 16;
   localparam int EE_AW    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [LIST_LEN*8-1:0] list_i = '0;
   logic busy_o, done_o, err_o, ovf_o, rm_rd_o, ee_valid_o;
   logic [RM_AW-1:0] rm_addr_o;
   logic [7:0] rm_data_i = '0;
   logic ee_ready_i = 1'b0;
   logic [EE_AW-1:0] ee_addr_o;
   logic [7:0] ee_data_o;

   always #5 clk = ~clk;

   eesave_seq #(.LIST_LEN(LIST_LEN), .RM_AW(RM_AW), .EE_AW(EE_AW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .list_i(list_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .ovf_o(ovf_o),
      .rm_rd_o(rm_rd_o), .rm_addr_o(rm_addr_o), .rm_data_i(rm_data_i),
      .ee_valid_o(ee_valid_o), .ee_ready_i(ee_ready_i),
      .ee_addr_o(ee_addr_o), .ee_data_o(ee_data_o));

   int checks = 0;
   int failures = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] rmf(input logic [15:0] a);
      return 8'(a[7:0] * 8'd7 + a[15:8] * 8'd13 + 8'h5A);
   endfunction

   // register map with one cycle of read latency
   always @(posedge clk) if (rm_rd_o) rm_data_i <= rmf(16'(rm_addr_o));

   // behavioural reference
   int    exp_a[$];
   int    exp_d[$];
   string exp_r[$];
   int    m_ptr;
   bit    exp_err, exp_ovf;

   function automatic logic [7:0] getb(input logic [LIST_LEN*8-1:0] l, input int i);
      if (i < LIST_LEN) return l[i*8 +: 8];
      return 8'hFF;
   endfunction

   task automatic push(input int d, input string r);
      exp_a.push_back(m_ptr);
      exp_d.push_back(d & 255);
      exp_r.push_back(r);
      if (m_ptr == (1 << EE_AW) - 1) exp_ovf = 1'b1;
      m_ptr = (m_ptr + 1) % (1 << EE_AW);
   endtask

   task automatic build_exp(input logic [LIST_LEN*8-1:0] l);
      int idx = 0;
      bit fin = 1'b0;
      exp_a.delete(); exp_d.delete(); exp_r.delete();
      m_ptr = 0; exp_err = 1'b0; exp_ovf = 1'b0;
      while (!fin) begin
         int op = getb(l, idx);
         if (op <= 8'h7F) begin
            int a = (getb(l, idx + 1) << 8) | getb(l, idx + 2);
            int s = 0;
            push(op, "R3");
            push(a >> 8, "R3");
            push(a & 255, "R3");
            for (int k = 0; k <= op; k++) begin
               int d = rmf(16'((a + k) & 16'hFFFF));
               push(d, "R4");
               s += d;
            end
            push((256 - (s & 255)) & 255, "R5");
            idx += 3;
         end else if (op == 8'h80) begin
            push(op, "R6");
            idx++;
         end else if (op == 8'hFF) begin
            push(op, "R7");
            fin = 1'b1;
         end else begin
            exp_err = 1'b1;
            idx++;
         end
      end
   endtask

   // per-clock monitor: drives ready, compares accepted writes
   int ready_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   bit prev_stall = 1'b0;
   logic [7:0] prev_d;
   logic [EE_AW-1:0] prev_a;

   always @(negedge clk) begin
      bit rdy;
      if (prev_stall)
         chk(ee_valid_o && ee_data_o == prev_d && ee_addr_o == prev_a,
             "R9", "held write during stall", int'(ee_data_o), int'(prev_d));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = (ready_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
      ee_ready_i = rdy;
      if (ee_valid_o && rdy) begin
         if (exp_d.size() == 0) begin
            chk(1'b0, "R7", "write after end", int'(ee_data_o), -1);
         end else begin
            chk(int'(ee_addr_o) == exp_a[0], "R10", "eeprom address",
                int'(ee_addr_o), exp_a[0]);
            chk(int'(ee_data_o) == exp_d[0], exp_r[0], "eeprom byte",
                int'(ee_data_o), exp_d[0]);
            void'(exp_a.pop_front());
            void'(exp_d.pop_front());
            void'(exp_r.pop_front());
         end
      end
      prev_stall = ee_valid_o && !rdy;
      prev_d = ee_data_o;
      prev_a = ee_addr_o;
   end

   task automatic run_list(input logic [LIST_LEN*8-1:0] l, input int rmode,
                           input bit midstart);
      int c = 0;
      bit seen = 1'b0;
      build_exp(l);
      ready_mode = rmode;
      @(negedge clk);
      list_i = l;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
      while (!seen && c < 20000) begin
         @(negedge clk);
         c++;
         if (midstart && c == 20) begin
            start_i = 1'b1;
            list_i = ~l;
         end
         if (midstart && c == 21) start_i = 1'b0;
         if (done_o) seen = 1'b1;
      end
      chk(seen, "R7", "done seen", int'(seen), 1);
      chk(busy_o == 1'b0, "R7", "busy low with done", int'(busy_o), 0);
      chk(exp_d.size() == 0, "R2", "writes left unmade", exp_d.size(), 0);
      chk(err_o == exp_err, "R8", "error flag", int'(err_o), int'(exp_err));
      chk(ovf_o == exp_ovf, "R10", "overflow flag", int'(ovf_o), int'(exp_ovf));
      @(negedge clk);
      chk(done_o == 1'b0, "R7", "done one cycle", int'(done_o), 0);
   endtask

   function automatic logic [LIST_LEN*8-1:0] example_list();
      logic [LIST_LEN*8-1:0] l = {LIST_LEN{8'hFF}};
      logic [7:0] b [14] = '{8'h08, 8'h04, 8'h00, 8'h15, 8'h05, 8'h00, 8'h80,
                             8'h03, 8'h06, 8'h00, 8'h01, 8'h06, 8'h40, 8'hFF};
      for (int i = 0; i < 14; i++) l[i*8 +: 8] = b[i];
      return l;
   endfunction

   initial begin
      logic [LIST_LEN*8-1:0] l;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(!busy_o && !done_o && !err_o && !ovf_o && !ee_valid_o && !rm_rd_o,
          "R1", "reset outputs",
          {busy_o, done_o, err_o, ovf_o, ee_valid_o, rm_rd_o}, 0);

      // R3 R4 R5 R6 R7: example layout, no stalls
      run_list(example_list(), 0, 1'b0);
      chk(ee_addr_o == 8'd55, "R10", "final pointer", int'(ee_addr_o), 55);

      // R2 R9: stalls plus a restart pulse and list change mid-run
      run_list(example_list(), 1, 1'b1);

      // R8 R4: bad opcodes, marker, copy wrapping from 0xFFFF
      l = {LIST_LEN{8'hFF}};
      l[0*8 +: 8] = 8'h90; l[1*8 +: 8] = 8'h80; l[2*8 +: 8] = 8'h01;
      l[3*8 +: 8] = 8'hFF; l[4*8 +: 8] = 8'hFF; l[5*8 +: 8] = 8'hC3;
      l[6*8 +: 8] = 8'h80;
      run_list(l, 1, 1'b0);

      // R8: error cleared by the next start
      run_list(example_list(), 0, 1'b0);

      // R10: pointer wraps past the last address
      l = {LIST_LEN{8'hFF}};
      l[0*8 +: 8] = 8'h7F; l[1*8 +: 8] = 8'h00; l[2*8 +: 8] = 8'h00;
      l[3*8 +: 8] = 8'h7F; l[4*8 +: 8] = 8'h01; l[5*8 +: 8] = 8'h00;
      run_list(l, 1, 1'b0);

      // R11: no end byte, copy address bytes past the list
      l = {LIST_LEN{8'h80}};
      l[15*8 +: 8] = 8'h00;
      run_list(l, 0, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R7", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule